// File: doc/BRIEF.md
# Time-Coded Lookup-Table Cell Array

This block is a small SIMD array of identical cells, 4 rows by 4 columns by default. Each cell keeps an 8-bit input value and an 8-bit state value. A program cycle evaluates a local rule across the whole array in the time domain. A shared digital ramp sweeps once over every 8-bit level, one level per clock. At each level, every cell turns its input and its state into one-bit pulse-width signals by comparing them with the ramp. Each cell then collects these pulses from its 3x3 neighbourhood to form two 9-bit addresses.

One address reads a shared 512-entry input-relation table and the other reads a shared 512-entry state-relation table. A 4-bit truth table combines the two one-bit results. Each cell counts the ramp levels at which the combined bit is high. When the sweep ends, that count becomes the cell's new state.

Before a cycle, software-side logic loads the tables through a one-bit write port and loads the cell values through an indexed load port. After the cycle, it reads the states back one cell at a time. A start pulse launches the sweep and a done pulse marks its end.

Top module: `tcl_array`

## Requirements
- R1: After a synchronous active-high reset, busy, done and rd_state are 0, and every cell's input and state value is 0.
- R2: When idle, ld_we writes ld_in and ld_st into cell ld_idx, where the cell index is row*COLS+column. rd_state shows the state of cell rd_idx one clock after rd_idx is sampled.
- R3: A start sampled while idle raises busy at that edge, with the ramp at 0. The ramp then takes 256 steps, 0 through 255, one per clock. busy falls and done is high for exactly one cycle at the 256th edge after the start edge.
- R4: At ramp value r, the encoded bit of a value v is 0 if v > r and 1 otherwise. A neighbour outside the array counts as value 0, so its bit is always 1.
- R5: Address bit (dr+1)*3+(dc+1) carries the neighbour at row offset dr and column offset dc, each in -1..1, where -1 means the row above or the column to the left. Bit 4 is the cell itself.
- R6: The input table (lut_sel=0) is addressed by the input-value bits and the state table (lut_sel=1) by the state-value bits. The state bits come from the states held before the cycle. All cells read the same two tables.
- R7: The combined bit is comb_tt[2*g+f], where g is the input-table bit and f is the state-table bit. comb_tt is captured at start, so later changes to it do not affect a running cycle.
- R8: The per-cell counter is cleared at start and adds 1 at each step where the combined bit is 1, saturating at 255. Its final value, including step 255, is written to the cell's state at the end of the cycle.
- R9: While busy, start, ld_we and lut_we are ignored.
- R10: When idle, lut_we writes lut_wdata into entry lut_addr of the table chosen by lut_sel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lut_we | input | 1 | Table entry write enable |
| lut_sel | input | 1 | Table select: 0 input relation, 1 state relation |
| lut_addr | input | 9 | Table entry address |
| lut_wdata | input | 1 | Table entry data |
| comb_tt | input | 4 | Truth table combining the two table bits |
| ld_we | input | 1 | Cell value load enable |
| ld_idx | input | IW (4) | Cell index for loading |
| ld_in | input | VW (8) | Input value to load |
| ld_st | input | VW (8) | State value to load |
| start | input | 1 | Begin a program cycle |
| rd_idx | input | IW (4) | Cell index for state readout |
| rd_state | output | VW (8) | Registered state of the selected cell |
| busy | output | 1 | Program cycle in progress |
| done | output | 1 | One-cycle pulse at the end of a cycle |

## Verification
A wrong encoding, address bit order or table selection only shows at the ports when a cycle finishes. It appears as a changed state count one readout after done, which is 257 clocks after start at the earliest. The directed cases are therefore built so that each such fault changes every affected cell's count by a predictable amount. The step counter and the end-of-cycle write show up sooner: a premature or missing done, or a state that changes while busy, appear at the ports in the very cycle they happen. The reference model compares busy, done and rd_state on every clock, so these faults are caught there and then.

// File: rtl/tcl_pkg.sv
package tcl_pkg;

  localparam int VAL_W    = 8;
  localparam int NBR_BITS = 9;

  typedef enum logic {
    TBL_IN = 1'b0,
    TBL_ST = 1'b1
  } tbl_sel_e;

  // Address bit carrying the neighbour at row offset dr, column offset dc.
  function automatic int nbr_bit(input int dr, input int dc);
    return (dr + 1) * 3 + (dc + 1);
  endfunction

endpackage

// File: rtl/tcl_seq.sv
module tcl_seq #(
  parameter int VW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          busy,
  output logic          done,
  output logic [VW-1:0] ramp,
  output logic          clr,
  output logic          step,
  output logic          last
);
  localparam logic [VW-1:0] RAMP_TOP = '1;

  assign clr  = start & ~busy;
  assign step = busy;
  assign last = busy && (ramp == RAMP_TOP);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      done <= 1'b0;
      ramp <= '0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        ramp <= ramp + 1'b1;
        if (ramp == RAMP_TOP) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end else if (start) begin
        busy <= 1'b1;
        ramp <= '0;
      end
    end
  end
endmodule

// File: rtl/tcl_lut.sv
module tcl_lut #(
  parameter int AW  = 9,
  parameter int NRD = 16
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [AW-1:0]           waddr,
  input  logic                    wdata,
  input  logic [NRD-1:0][AW-1:0]  raddr,
  output logic [NRD-1:0]          rdata
);
  localparam int DEPTH = 1 << AW;

  logic mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  for (genvar i = 0; i < NRD; i++) begin : g_rd
    assign rdata[i] = mem[raddr[i]];
  end
endmodule

// File: rtl/tcl_cell.sv
module tcl_cell #(
  parameter int VW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_en,
  input  logic [VW-1:0] ld_in,
  input  logic [VW-1:0] ld_st,
  input  logic [VW-1:0] ramp,
  input  logic          clr,
  input  logic          step,
  input  logic          last,
  input  logic          g_bit,
  input  logic          f_bit,
  input  logic [3:0]    tt,
  output logic          u_enc,
  output logic          x_enc,
  output logic [VW-1:0] state_q
);
  logic [VW-1:0] in_q, st_q, acc_q, acc_nx;
  logic          comp;

  // Pulse is low while the stored value is above the ramp.
  assign u_enc   = (in_q <= ramp);
  assign x_enc   = (st_q <= ramp);
  assign comp    = tt[{g_bit, f_bit}];
  assign state_q = st_q;

  always_comb begin
    acc_nx = acc_q;
    if (comp && (acc_q != '1)) acc_nx = acc_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_q  <= '0;
      st_q  <= '0;
      acc_q <= '0;
    end else begin
      if (ld_en) begin
        in_q <= ld_in;
        st_q <= ld_st;
      end else if (last) begin
        st_q <= acc_nx;
      end
      if (clr)       acc_q <= '0;
      else if (step) acc_q <= acc_nx;
    end
  end
endmodule

// File: rtl/tcl_array.sv
module tcl_array
  import tcl_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  parameter int VW   = VAL_W,
  parameter int IW   = $clog2(ROWS * COLS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                lut_we,
  input  logic                lut_sel,
  input  logic [NBR_BITS-1:0] lut_addr,
  input  logic                lut_wdata,
  input  logic [3:0]          comb_tt,
  input  logic                ld_we,
  input  logic [IW-1:0]       ld_idx,
  input  logic [VW-1:0]       ld_in,
  input  logic [VW-1:0]       ld_st,
  input  logic                start,
  input  logic [IW-1:0]       rd_idx,
  output logic [VW-1:0]       rd_state,
  output logic                busy,
  output logic                done
);
  localparam int NCELL = ROWS * COLS;

  logic [VW-1:0]                      ramp_q;
  logic                               clr, step, last;
  logic [3:0]                         tt_q;
  logic                               wr_ok, g_we, f_we;
  logic [NCELL-1:0]                   u_enc, x_enc, g_bits, f_bits;
  logic [NCELL-1:0][NBR_BITS-1:0]     u_addr, x_addr;
  logic [VW-1:0]                      st_all [NCELL];

  tcl_seq #(.VW(VW)) u_seq (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .ramp(ramp_q), .clr(clr), .step(step), .last(last)
  );

  assign wr_ok = lut_we & ~busy;
  assign g_we  = wr_ok & (tbl_sel_e'(lut_sel) == TBL_IN);
  assign f_we  = wr_ok & (tbl_sel_e'(lut_sel) == TBL_ST);

  tcl_lut #(.AW(NBR_BITS), .NRD(NCELL)) u_lut_g (
    .clk(clk), .we(g_we), .waddr(lut_addr), .wdata(lut_wdata),
    .raddr(u_addr), .rdata(g_bits)
  );

  tcl_lut #(.AW(NBR_BITS), .NRD(NCELL)) u_lut_f (
    .clk(clk), .we(f_we), .waddr(lut_addr), .wdata(lut_wdata),
    .raddr(x_addr), .rdata(f_bits)
  );

  always_ff @(posedge clk) begin
    if (rst)      tt_q <= '0;
    else if (clr) tt_q <= comb_tt;
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      localparam int ID = r * COLS + c;

      tcl_cell #(.VW(VW)) u_cell (
        .clk(clk), .rst(rst),
        .ld_en(ld_we & ~busy & (ld_idx == IW'(ID))),
        .ld_in(ld_in), .ld_st(ld_st), .ramp(ramp_q),
        .clr(clr), .step(step), .last(last),
        .g_bit(g_bits[ID]), .f_bit(f_bits[ID]), .tt(tt_q),
        .u_enc(u_enc[ID]), .x_enc(x_enc[ID]), .state_q(st_all[ID])
      );

      for (genvar dr = -1; dr <= 1; dr++) begin : g_dr
        for (genvar dc = -1; dc <= 1; dc++) begin : g_dc
          localparam int K  = nbr_bit(dr, dc);
          localparam int NR = r + dr;
          localparam int NC = c + dc;
          if (NR >= 0 && NR < ROWS && NC >= 0 && NC < COLS) begin : g_in
            assign u_addr[ID][K] = u_enc[NR * COLS + NC];
            assign x_addr[ID][K] = x_enc[NR * COLS + NC];
          end else begin : g_edge
            // A zero value never exceeds the ramp.
            assign u_addr[ID][K] = 1'b1;
            assign x_addr[ID][K] = 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_state <= '0;
    else     rd_state <= st_all[rd_idx];
  end
endmodule

// File: rtl/tcl_array_chk.sv
module tcl_array_chk #(
  parameter int IW = 4,
  parameter int VW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic [VW-1:0] ramp,
  input logic [IW-1:0] rd_idx,
  input logic [VW-1:0] rd_state
);
  assert_done_single_R3: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_at_fall_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  assert_done_idle_R3: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_start_ramp_zero_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (ramp == '0 && $past(start)));

  assert_final_step_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && ramp == '1) |=> (done && !busy));

  assert_state_frozen_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && $past(rd_idx) == $past(rd_idx, 2)) |-> $stable(rd_state));
endmodule

bind tcl_array tcl_array_chk #(.IW(IW), .VW(VW)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .ramp(ramp_q), .rd_idx(rd_idx), .rd_state(rd_state)
);

// File: tb/tcl_array_tb.sv
module tcl_array_tb;
  localparam int ROWS = 4;
  localparam int COLS = 4;
  localparam int N    = ROWS * COLS;
  localparam int IW   = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       lut_we = 0, lut_sel = 0, lut_wdata = 0;
  logic [8:0] lut_addr = '0;
  logic [3:0] comb_tt = '0;
  logic       ld_we = 0;
  logic [IW-1:0] ld_idx = '0, rd_idx = '0;
  logic [7:0] ld_in = '0, ld_st = '0;
  logic       start = 0;
  logic [7:0] rd_state;
  logic       busy, done;

  always #5 clk = ~clk;

  tcl_array u_dut (
    .clk(clk), .rst(rst), .lut_we(lut_we), .lut_sel(lut_sel),
    .lut_addr(lut_addr), .lut_wdata(lut_wdata), .comb_tt(comb_tt),
    .ld_we(ld_we), .ld_idx(ld_idx), .ld_in(ld_in), .ld_st(ld_st),
    .start(start), .rd_idx(rd_idx), .rd_state(rd_state),
    .busy(busy), .done(done)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  task automatic chk(input string tag, input int act, input int expv, input string what);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int  m_in [N];
  int  m_st [N];
  int  m_acc [N];
  bit  m_g [512];
  bit  m_f [512];
  int  m_ramp = 0;
  int  m_rd = 0;
  bit  m_busy = 0, m_done = 0;
  logic [3:0] m_tt = '0;
  int  cur_st [N];

  function automatic int nval(input int r, input int c, input bit use_st);
    if (r < 0 || r >= ROWS || c < 0 || c >= COLS) return 0;
    return use_st ? m_st[r*COLS+c] : m_in[r*COLS+c];
  endfunction

  function automatic int addr_of(input int r, input int c, input bit use_st, input int rp);
    int a = 0;
    for (int dr = -1; dr <= 1; dr++)
      for (int dc = -1; dc <= 1; dc++)
        if (nval(r+dr, c+dc, use_st) <= rp) a |= 1 << ((dr+1)*3 + (dc+1));
    return a;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_done = 0; m_rd = 0; m_ramp = 0;
      for (int i = 0; i < N; i++) begin m_in[i] = 0; m_st[i] = 0; m_acc[i] = 0; end
    end else begin
      int  nrd;
      bit  nb, nd;
      nrd = m_st[rd_idx];
      nb  = m_busy;
      nd  = 0;
      if (m_busy) begin
        for (int i = 0; i < N; i++) begin
          bit g, f, cb;
          g  = m_g[addr_of(i/COLS, i%COLS, 0, m_ramp)];
          f  = m_f[addr_of(i/COLS, i%COLS, 1, m_ramp)];
          cb = m_tt[g*2+f];
          if (cb && m_acc[i] < 255) m_acc[i]++;
        end
        if (m_ramp == 255) begin
          for (int i = 0; i < N; i++) m_st[i] = m_acc[i];
          nb = 0; nd = 1;
        end
        m_ramp = (m_ramp + 1) % 256;
      end else begin
        if (lut_we) begin
          if (lut_sel) m_f[lut_addr] = lut_wdata;
          else         m_g[lut_addr] = lut_wdata;
        end
        if (ld_we) begin m_in[ld_idx] = ld_in; m_st[ld_idx] = ld_st; end
        if (start) begin
          nb = 1; m_ramp = 0; m_tt = comb_tt;
          for (int i = 0; i < N; i++) m_acc[i] = 0;
        end
      end
      m_busy = nb; m_done = nd; m_rd = nrd;
    end
  end

  // every-clock comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      chk("R3", int'(busy), int'(m_busy), "busy vs model");
      chk("R3", int'(done), int'(m_done), "done vs model");
      chk("R2", int'(rd_state), m_rd, "rd_state vs model");
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL R3 watchdog actual=%0d expected=below 150000 cycles", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  // ---------------- stimulus helpers ----------------
  function automatic int in_v(input int i);  return (i * 17) % 256; endfunction
  function automatic int st_v(input int i);  return (i * 37 + 11) % 256; endfunction
  function automatic int sat(input int v);   return (v > 255) ? 255 : v; endfunction

  task automatic lut_fill(input bit sel, input int bitpos);
    for (int a = 0; a < 512; a++) begin
      @(negedge clk);
      lut_we = 1; lut_sel = sel; lut_addr = 9'(a);
      lut_wdata = (bitpos < 0) ? 1'b0 : 1'((a >> bitpos) & 1);
    end
    @(negedge clk);
    lut_we = 0;
  endtask

  task automatic load(input int idx, input int iv, input int sv);
    @(negedge clk);
    ld_we = 1; ld_idx = IW'(idx); ld_in = 8'(iv); ld_st = 8'(sv);
    @(negedge clk);
    ld_we = 0;
  endtask

  task automatic read_chk(input int idx, input int expv, input string tag);
    @(negedge clk);
    rd_idx = IW'(idx);
    @(negedge clk);
    chk(tag, int'(rd_state), expv, $sformatf("state of cell %0d", idx));
  endtask

  task automatic run(input logic [3:0] tt, input bit disturb);
    int n;
    @(negedge clk);
    comb_tt = tt; start = 1;
    @(negedge clk);
    start = 0;
    n = 1;
    while (!done && n < 400) begin
      @(negedge clk);
      n++;
      if (disturb && n == 10) begin   // R9 stimulus while busy
        ld_we = 1; ld_idx = 4'd5; ld_in = 8'd7; ld_st = 8'd7;
        lut_we = 1; lut_sel = 0; lut_addr = 9'h1FF; lut_wdata = 0;
        start = 1; comb_tt = 4'b0000;
      end else if (disturb && n == 11) begin
        ld_we = 0; lut_we = 0; start = 0;
      end
    end
    chk("R3", n - 1, 256, "edges from start to done");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state
    chk("R1", int'(busy), 0, "busy after reset");
    chk("R1", int'(done), 0, "done after reset");
    chk("R1", int'(rd_state), 0, "rd_state after reset");
    for (int i = 0; i < N; i++) read_chk(i, 0, "R1");

    // R2: loads and readout
    for (int i = 0; i < N; i++) load(i, in_v(i), st_v(i));
    for (int i = 0; i < N; i++) read_chk(i, st_v(i), "R2");

    // R4 R8 R9 R10: self bit of input table, disturbance while busy
    lut_fill(0, 4);
    lut_fill(1, -1);
    run(4'b1100, 1);
    for (int i = 0; i < N; i++) begin
      cur_st[i] = sat(256 - in_v(i));
      read_chk(i, cur_st[i], "R9_R8_R4");
    end

    // R5 R4: up-left neighbour bit, edge cells see value 0
    lut_fill(0, 0);
    run(4'b1100, 0);
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin
        int v;
        v = (r > 0 && c > 0) ? in_v((r-1)*COLS + c-1) : 0;
        read_chk(r*COLS+c, sat(256 - v), "R5");
      end

    // R6 R7: both tables on self bit, XOR composition, old states used
    for (int i = 0; i < N; i++) load(i, in_v(i), st_v(i));
    lut_fill(0, 4);
    lut_fill(1, 4);
    run(4'b0110, 0);
    for (int i = 0; i < N; i++) begin
      int d;
      d = in_v(i) - st_v(i);
      cur_st[i] = (d < 0) ? -d : d;
      read_chk(i, cur_st[i], "R6_R7");
    end

    // R7: only the both-low term
    run(4'b0001, 0);
    for (int i = 0; i < N; i++) begin
      int e;
      e = (in_v(i) < cur_st[i]) ? in_v(i) : cur_st[i];
      read_chk(i, e, "R7");
    end

    // R8: constant one saturates, constant zero clears the counter
    run(4'b1111, 0);
    for (int i = 0; i < N; i++) read_chk(i, 255, "R8");
    run(4'b0000, 0);
    for (int i = 0; i < N; i++) read_chk(i, 0, "R8");

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule